// File: doc/BRIEF.md
# Pin Bias Configuration Register Bank

This block keeps a two-bit bias choice for every pin across several GPIO banks and drives each code straight to the pad ring. Software reaches the settings through a small synchronous register bus made of a byte address, a write strobe, 32 bits of write data and 32 bits of registered read data. Every register word holds the fields of eight pins in its low half-word. The high half-word of a write is a bit-by-bit enable, so one pin's field can change without first reading the register back.

There are two address windows. The main window serves most pins and packs each register in descending pin order, so the first pin of a word sits at the top of the half-word. The first twelve pins of bank 0 are served only by a separate auxiliary window, which packs pins in ascending order. Because of this, the first main-window word holds only bank 0 pins 12 to 15. Its slots for pins 8 to 11 are dead.

Top module: `bias_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every pad field and `rd_data` become 0 (no bias).
- R2: The field codes are 0 for no bias, 1 for pull-up, 2 for pull-down and 3 for bus keeper. Pin `p` of bank `b` (global index g = 32b + p) drives `pad_bias[2g+1:2g]` with its stored code.
- R3: On a write, data bit i (0..15) is stored only if `wr_data[16+i]` is 1. Every other stored bit keeps its value, including a single bit of a two-bit field.
- R4: A write whose bits 31:16 are all 0 changes nothing.
- R5: Main window: pin p of bank b is at byte offset 16b + 4(p/8) − 4, in bits 15−2j:14−2j where j = p mod 8. This applies to every pin except bank 0 pins 0 to 11.
- R6: Auxiliary window: bank 0 pin p (p < 12) is at byte offset 0x40 + 4(p/8), in bits 2j+1:2j where j = p mod 8.
- R7: At main offset 0x00, bits 15:8 (the slots of bank 0 pins 8..11) read 0 and ignore writes. Bits 7:0 serve pins 12..15.
- R8: At auxiliary offset 0x44, bits 15:8 read 0 and ignore writes.
- R9: `rd_data` is registered. After a clock edge it shows bits 15:0 of the register addressed at that edge, as held before any write at that same edge, and bits 31:16 read 0.
- R10: Offsets 0x3C, 0x48 to 0xFC and any offset not a multiple of 4 read 0, and writes to them change no pad field.
- R11: A pad output reflects a write from the first cycle after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Enables in 31:16, field data in 15:0 |
| rd_data | output | 32 | Registered read data |
| pad_bias | output | 256 | Two-bit bias code per pin, pin g at bits 2g+1:2g |

## Verification
A read and a write can land on the same register in the same cycle. The bench provokes this by raising the write strobe while it queues a read of that same offset. The scoreboard expects the contents from before the write, and a plain read in a later cycle must return the merged value. The same bench cycle also compares every pad field against the reference model, so the old read value and the new pad value are judged at one edge.

// File: rtl/bias_pkg.sv
package bias_pkg;
  localparam int BIAS_W   = 2;
  localparam int HALF_W   = 16;
  localparam int BUS_W    = 32;

  typedef enum logic [BIAS_W-1:0] {
    BIAS_NONE = 2'd0,
    BIAS_UP   = 2'd1,
    BIAS_DOWN = 2'd2,
    BIAS_KEEP = 2'd3
  } bias_e;
endpackage

// File: rtl/bias_addr_map.sv
module bias_addr_map #(
  parameter int ADDR_W        = 8,
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 32,
  parameter int PINS_PER_REG  = 8,
  parameter int AUX_PINS      = 12,
  parameter int AUX_OFFSET    = 64,
  parameter int PIN_W         = 7
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic [PIN_W-1:0]        base_pin,
  output logic                    reversed,
  output logic [PINS_PER_REG-1:0] slot_ok
);
  localparam int REGS_PER_BANK = PINS_PER_BANK / PINS_PER_REG;
  localparam int MAIN_WORDS    = NUM_BANKS * REGS_PER_BANK - 1;
  localparam int AUX_WORDS     = (AUX_PINS + PINS_PER_REG - 1) / PINS_PER_REG;
  localparam int AUX_WORD0     = AUX_OFFSET / 4;

  always_comb begin
    int word;
    int first;
    word     = int'(addr[ADDR_W-1:2]);
    first    = 0;
    reversed = 1'b0;
    slot_ok  = '0;
    if (addr[1:0] == 2'b00) begin
      if (word < MAIN_WORDS) begin
        first    = (word + 1) * PINS_PER_REG;
        reversed = 1'b1;
        for (int s = 0; s < PINS_PER_REG; s++)
          slot_ok[s] = (first + s) >= AUX_PINS;
      end else if (word >= AUX_WORD0 && word < AUX_WORD0 + AUX_WORDS) begin
        first = (word - AUX_WORD0) * PINS_PER_REG;
        for (int s = 0; s < PINS_PER_REG; s++)
          slot_ok[s] = (first + s) < AUX_PINS;
      end
    end
    base_pin = PIN_W'(first);
  end
endmodule

// File: rtl/bias_pin_cell.sv
module bias_pin_cell
  import bias_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [BIAS_W-1:0] bit_en,
  input  logic [BIAS_W-1:0] bit_val,
  output logic [BIAS_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst)
      code <= BIAS_NONE;
    else if (sel)
      code <= (code & ~bit_en) | (bit_val & bit_en);
  end
endmodule

// File: rtl/bias_rd_pack.sv
module bias_rd_pack
  import bias_pkg::*;
#(
  parameter int NUM_PINS     = 128,
  parameter int PINS_PER_REG = 8,
  parameter int PIN_W        = 7
) (
  input  logic [NUM_PINS*BIAS_W-1:0] codes,
  input  logic [PIN_W-1:0]           base_pin,
  input  logic                       reversed,
  input  logic [PINS_PER_REG-1:0]    slot_ok,
  output logic [HALF_W-1:0]          word
);
  always_comb begin
    int idx;
    int pos;
    word = '0;
    for (int s = 0; s < PINS_PER_REG; s++) begin
      idx = int'(base_pin) + s;
      pos = reversed ? (PINS_PER_REG - 1 - s) * BIAS_W : s * BIAS_W;
      if (slot_ok[s] && idx < NUM_PINS)
        word[pos +: BIAS_W] = codes[idx*BIAS_W +: BIAS_W];
    end
  end
endmodule

// File: rtl/bias_bank.sv
module bias_bank
  import bias_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 32,
  parameter int PINS_PER_REG  = 8,
  parameter int AUX_PINS      = 12,
  parameter int AUX_OFFSET    = 64,
  localparam int NUM_PINS     = NUM_BANKS * PINS_PER_BANK,
  localparam int PIN_W        = $clog2(NUM_PINS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic [BUS_W-1:0]           wr_data,
  output logic [BUS_W-1:0]           rd_data,
  output logic [NUM_PINS*BIAS_W-1:0] pad_bias
);
  logic [PIN_W-1:0]        base_pin;
  logic                    reversed;
  logic [PINS_PER_REG-1:0] slot_ok;
  logic [HALF_W-1:0]       rd_word;

  bias_addr_map #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .PINS_PER_BANK(PINS_PER_BANK),
    .PINS_PER_REG(PINS_PER_REG), .AUX_PINS(AUX_PINS),
    .AUX_OFFSET(AUX_OFFSET), .PIN_W(PIN_W)
  ) u_map (
    .addr(addr), .base_pin(base_pin), .reversed(reversed), .slot_ok(slot_ok)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic              hit;
    logic [BIAS_W-1:0] en2;
    logic [BIAS_W-1:0] val2;

    always_comb begin
      int slot;
      int pos;
      hit  = 1'b0;
      en2  = '0;
      val2 = '0;
      pos  = 0;
      slot = g - int'(base_pin);
      if (slot >= 0 && slot < PINS_PER_REG) begin
        if (slot_ok[slot]) begin
          hit  = 1'b1;
          pos  = reversed ? (PINS_PER_REG - 1 - slot) * BIAS_W : slot * BIAS_W;
          en2  = wr_data[HALF_W + pos +: BIAS_W];
          val2 = wr_data[pos +: BIAS_W];
        end
      end
    end

    bias_pin_cell u_cell (
      .clk(clk), .rst(rst), .sel(hit && wr_en),
      .bit_en(en2), .bit_val(val2),
      .code(pad_bias[g*BIAS_W +: BIAS_W])
    );
  end

  bias_rd_pack #(
    .NUM_PINS(NUM_PINS), .PINS_PER_REG(PINS_PER_REG), .PIN_W(PIN_W)
  ) u_pack (
    .codes(pad_bias), .base_pin(base_pin), .reversed(reversed),
    .slot_ok(slot_ok), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else
      rd_data <= {{(BUS_W-HALF_W){1'b0}}, rd_word};
  end
endmodule

// File: rtl/bias_bank_chk.sv
module bias_bank_chk #(
  parameter int ADDR_W        = 8,
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 32,
  parameter int PINS_PER_REG  = 8,
  parameter int AUX_PINS      = 12,
  parameter int AUX_OFFSET    = 64
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic [ADDR_W-1:0]                     addr,
  input logic                                  wr_en,
  input logic [31:0]                           wr_data,
  input logic [31:0]                           rd_data,
  input logic [NUM_BANKS*PINS_PER_BANK*2-1:0]  pad_bias
);
  localparam int MAIN_WORDS = NUM_BANKS * (PINS_PER_BANK / PINS_PER_REG) - 1;
  localparam int AUX_WORDS  = (AUX_PINS + PINS_PER_REG - 1) / PINS_PER_REG;
  localparam int AUX_WORD0  = AUX_OFFSET / 4;

  logic mapped;
  logic rst_q;
  int   word_ix;

  always_comb begin
    word_ix = int'(addr[ADDR_W-1:2]);
    mapped  = (addr[1:0] == 2'b00) &&
              ((word_ix < MAIN_WORDS) ||
               (word_ix >= AUX_WORD0 && word_ix < AUX_WORD0 + AUX_WORDS));
  end

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_CLEAR: assert (pad_bias == '0 && rd_data == '0); // R1
    end
  end

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:16] == 16'h0); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pad_bias)); // R3

  AST_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[31:16] == 16'h0) |=> $stable(pad_bias)); // R4

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> rd_data == 32'h0); // R10

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mapped) |=> $stable(pad_bias)); // R10

  AST_MAIN0_DEAD: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |=> rd_data[15:8] == 8'h0); // R7

  AST_AUX1_DEAD: assert property (@(posedge clk) disable iff (rst)
    (int'(addr) == AUX_OFFSET + 4) |=> rd_data[15:8] == 8'h0); // R8
endmodule

bind bias_bank bias_bank_chk #(
  .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .PINS_PER_BANK(PINS_PER_BANK),
  .PINS_PER_REG(PINS_PER_REG), .AUX_PINS(AUX_PINS), .AUX_OFFSET(AUX_OFFSET)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pad_bias(pad_bias)
);

// File: tb/bias_bank_tb.sv
module bias_bank_tb;
  localparam int NPINS = 128;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       addr = '0;
  logic             wr_en = 1'b0;
  logic [31:0]      wr_data = '0;
  logic [31:0]      rd_data;
  logic [NPINS*2-1:0] pad_bias;

  int total = 0;
  int bad   = 0;
  logic rd_req = 1'b0;
  logic took   = 1'b0;
  logic [31:0] q_exp[$];
  string       q_tag[$];
  logic [1:0]  mdl [NPINS];

  always #4 clk = ~clk;

  bias_bank u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_bias(pad_bias)
  );

  function automatic int off_of(int g);
    int b = g / 32;
    int p = g % 32;
    if (b == 0 && p < 12) return 64 + (p / 8) * 4;
    return b * 16 + (p / 8) * 4 - 4;
  endfunction

  function automatic int pos_of(int g);
    int b = g / 32;
    int p = g % 32;
    if (b == 0 && p < 12) return (p % 8) * 2;
    return (7 - p % 8) * 2;
  endfunction

  function automatic logic [31:0] model_read(int a);
    logic [31:0] r = '0;
    for (int g = 0; g < NPINS; g++)
      if (off_of(g) == a) r[pos_of(g) +: 2] = mdl[g];
    return r;
  endfunction

  function automatic logic [NPINS*2-1:0] model_pads();
    logic [NPINS*2-1:0] v;
    for (int g = 0; g < NPINS; g++) v[g*2 +: 2] = mdl[g];
    return v;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [NPINS*2-1:0] act, input logic [NPINS*2-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int a, input bit wen, input logic [31:0] wd,
                      input bit rd, input string tag);
    @(negedge clk);
    addr = 8'(a); wr_en = wen; wr_data = wd; rd_req = rd;
    if (rd) begin
      q_exp.push_back(model_read(a));
      q_tag.push_back(tag);
    end
    if (wen)
      for (int g = 0; g < NPINS; g++)
        if (off_of(g) == a)
          for (int i = 0; i < 2; i++)
            if (wd[16 + pos_of(g) + i]) mdl[g][i] = wd[pos_of(g) + i];
    @(negedge clk);
    wr_en = 1'b0; rd_req = 1'b0;
    check(pad_bias == model_pads(), {"R11 pads ", tag}, pad_bias, model_pads());
  endtask

  always @(posedge clk) took <= rd_req;

  always @(negedge clk) begin
    if (took) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R9 read with empty scoreboard", rd_data, '0);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(rd_data == e, {"read ", t}, rd_data, e);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int g = 0; g < NPINS; g++) mdl[g] = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pad_bias == '0 && rd_data == '0, "R1 reset state", pad_bias, '0);
    rst = 1'b0;
    xfer(8'h00, 0, 0, 1, "R1 read after reset");
    // bank 1 pin 0 pull-up, reversed order: bits 15:14 at offset 0x0C
    xfer(8'h0C, 1, 32'hC000_4000, 0, "R5 bank1 pin0 pull-up");
    xfer(8'h0C, 0, 0, 1, "R2 R5 readback 0x4000");
    xfer(8'h0C, 1, 32'h0300_0200, 0, "R3 pin3 pull-down only");
    xfer(8'h0C, 0, 0, 1, "R3 readback 0x4200");
    xfer(8'h0C, 1, 32'h0000_FFFF, 0, "R4 zero enables");
    xfer(8'h0C, 0, 0, 1, "R4 readback unchanged");
    xfer(8'h0C, 1, 32'h8000_8000, 0, "R3 single bit of field");
    xfer(8'h0C, 0, 0, 1, "R3 readback 0xC200");
    xfer(8'h40, 1, 32'hFFFF_1B1B, 0, "R6 aux pins 0..7");
    xfer(8'h40, 0, 0, 1, "R6 aux readback");
    xfer(8'h44, 1, 32'hFFFF_FF55, 0, "R8 aux pins 8..11");
    xfer(8'h44, 0, 0, 1, "R8 aux upper read zero");
    xfer(8'h00, 1, 32'hFFFF_FFFF, 0, "R7 main offset 0");
    xfer(8'h00, 0, 0, 1, "R7 main0 upper read zero");
    xfer(8'h44, 0, 0, 1, "R7 aux pins kept");
    xfer(8'h38, 1, 32'h0003_0002, 0, "R5 bank3 pin31 pull-down");
    xfer(8'h38, 0, 0, 1, "R5 bank3 readback");
    xfer(8'h3C, 1, 32'hFFFF_FFFF, 1, "R10 offset 0x3C");
    xfer(8'h48, 1, 32'hFFFF_FFFF, 1, "R10 offset 0x48");
    xfer(8'hFC, 1, 32'hFFFF_FFFF, 1, "R10 offset 0xFC");
    xfer(8'h0D, 1, 32'hFFFF_FFFF, 1, "R10 misaligned");
    xfer(8'h0C, 1, 32'hFFFF_0000, 1, "R9 same-cycle read sees old");
    xfer(8'h0C, 0, 0, 1, "R9 later read sees new");
    for (int i = 0; i < 18; i++)
      xfer(i * 4, 1, {16'hFFFF, 16'(i * 16'h1357 + 16'h2468)}, 0, "R2 sweep write");
    for (int i = 0; i < 18; i++)
      xfer(i * 4, 0, 0, 1, "R2 sweep read");
    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R9 scoreboard drained", NPINS*2'(q_exp.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule